// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the one memory reservation shared by every thread of a core that runs atomic read-modify-write sequences. A load-linked request, in either the 32-bit word or the 64-bit doubleword flavour, records the exact address, the requesting thread and the width kind. A later store-conditional is granted only when the reservation is still live and matches all three. A granted store-conditional consumes the reservation.

A snoop port sees every memory write in the system. A write with any byte enabled inside the aligned 8-byte block that holds the reserved address kills the reservation. The store-conditional answer is combinational in the request cycle. It is judged against the reservation as it stood before that clock edge. The granted store address is handed back already aligned to the access width. Data and memory stay outside the block.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset no reservation is held, so any store-conditional of either width fails. This includes one to address 0 from thread 0.
- R2: A word load-linked (`link_dword`=0) followed by a word store-conditional with the same thread and the same address raises `sc_ok` and `store_en` in the request cycle.
- R3: A doubleword load-linked (`link_dword`=1) followed by a doubleword store-conditional (`cond_dword`=1) with the same thread and the same address succeeds in the same way.
- R4: A word store-conditional cannot use a doubleword reservation, and a doubleword store-conditional cannot use a word reservation.
- R5: A store-conditional from a thread other than the one that made the reservation fails.
- R6: The address compare covers all address bits. An address that differs only in its low bits fails.
- R7: A new load-linked replaces any earlier reservation, including its owner, address and width.
- R8: A snoop write with `snoop_be` nonzero clears the reservation when `snoop_addr` and the reserved address agree above bit 2. A snoop to another 8-byte block, or one with `snoop_be` = 0, leaves the reservation intact.
- R9: A successful store-conditional clears the reservation, so an identical retry in the next cycle fails.
- R10: A failed store-conditional drives `sc_ok`=0, `store_en`=0 and `store_addr`=0, and it leaves the reservation unchanged. Without a request all three outputs are 0.
- R11: On success, `store_addr` is the request address with bits 1:0 cleared for a word, or with bits 2:0 cleared for a doubleword.
- R12: When requests meet in one cycle, the store-conditional is judged on the old reservation. A load-linked in that cycle then wins over both the success clear and the snoop clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_valid | input | 1 | Load-linked request |
| link_dword | input | 1 | 1 = doubleword load-linked, 0 = word |
| link_addr | input | ADDR_W | Load-linked address |
| link_tid | input | TID_W | Requesting thread |
| cond_valid | input | 1 | Store-conditional request |
| cond_dword | input | 1 | 1 = doubleword store-conditional, 0 = word |
| cond_addr | input | ADDR_W | Store-conditional address |
| cond_tid | input | TID_W | Requesting thread |
| snoop_valid | input | 1 | A memory write is taking place |
| snoop_addr | input | ADDR_W | Address of the snooped write |
| snoop_be | input | BE_W | Byte enables of the snooped write |
| sc_ok | output | 1 | Store-conditional result (1 = success) |
| store_en | output | 1 | Permission to perform the store |
| store_addr | output | ADDR_W | Aligned store address, 0 when not granted |

## Verification
The bench targets the width-kind cross check in both directions. A design that ignored the kind would let a word store-conditional consume a doubleword reservation. It also probes low-bit address differences that a block-level compare would wrongly accept. For snoops, it uses writes in the neighbouring 8-byte block and writes with all byte enables off, which a sloppy snoop would treat as hits.

Same-cycle collisions get their own steps. A load-linked paired with a store-conditional, or with a hitting snoop, must leave the new reservation live. A design with the wrong priority would lose it, or would grant the store-conditional against a reservation that did not yet exist. Immediate retries after success expose a monitor that forgets to consume the reservation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    // Width kind of the held reservation; the codes are visible to the checker.
    typedef enum logic [1:0] {
        RK_NONE  = 2'd0,
        RK_WORD  = 2'd1,
        RK_DWORD = 2'd2
    } resv_kind_e;

    localparam int WORD_BYTES  = 4;
    localparam int DWORD_BYTES = 8;

    function automatic resv_kind_e kind_of(input logic dword);
        return dword ? RK_DWORD : RK_WORD;
    endfunction

endpackage

// File: rtl/llsc_cond_match.sv
module llsc_cond_match #(
    parameter int ADDR_W = 64,
    parameter int TID_W  = 8
) (
    input  llsc_pkg::resv_kind_e  kind_q,
    input  logic [ADDR_W-1:0]     addr_q,
    input  logic [TID_W-1:0]      owner_q,
    input  logic                  cond_valid,
    input  logic                  cond_dword,
    input  logic [ADDR_W-1:0]     cond_addr,
    input  logic [TID_W-1:0]      cond_tid,
    output logic                  grant
);
    import llsc_pkg::*;

    logic kind_ok;
    logic owner_ok;
    logic addr_ok;

    always_comb begin
        kind_ok  = (kind_q != RK_NONE) && (kind_q == kind_of(cond_dword));
        owner_ok = (owner_q == cond_tid);
        addr_ok  = (addr_q == cond_addr);
        grant    = cond_valid && kind_ok && owner_ok && addr_ok;
    end

endmodule

// File: rtl/llsc_snoop_hit.sv
module llsc_snoop_hit #(
    parameter int ADDR_W = 64,
    parameter int BE_W   = 8
) (
    input  llsc_pkg::resv_kind_e  kind_q,
    input  logic [ADDR_W-1:0]     addr_q,
    input  logic                  snoop_valid,
    input  logic [ADDR_W-1:0]     snoop_addr,
    input  logic [BE_W-1:0]       snoop_be,
    output logic                  kill
);
    import llsc_pkg::*;

    localparam logic [ADDR_W-1:0] BLOCK_MASK = ~(ADDR_W'(BE_W) - ADDR_W'(1));

    logic same_block;
    logic writes_bytes;

    always_comb begin
        same_block   = ((snoop_addr & BLOCK_MASK) == (addr_q & BLOCK_MASK));
        writes_bytes = |snoop_be;
        kill         = snoop_valid && writes_bytes && same_block && (kind_q != RK_NONE);
    end

endmodule

// File: rtl/llsc_store_align.sv
module llsc_store_align #(
    parameter int ADDR_W = 64
) (
    input  logic               grant,
    input  logic               dword,
    input  logic [ADDR_W-1:0]  addr,
    output logic [ADDR_W-1:0]  store_addr
);
    import llsc_pkg::*;

    localparam logic [ADDR_W-1:0] W_MASK = ~(ADDR_W'(WORD_BYTES)  - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] D_MASK = ~(ADDR_W'(DWORD_BYTES) - ADDR_W'(1));

    always_comb begin
        if (!grant) begin
            store_addr = '0;
        end else if (dword) begin
            store_addr = addr & D_MASK;
        end else begin
            store_addr = addr & W_MASK;
        end
    end

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
    parameter int ADDR_W = 64,
    parameter int TID_W  = 8,
    parameter int BE_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_valid,
    input  logic               link_dword,
    input  logic [ADDR_W-1:0]  link_addr,
    input  logic [TID_W-1:0]   link_tid,
    input  logic               cond_valid,
    input  logic               cond_dword,
    input  logic [ADDR_W-1:0]  cond_addr,
    input  logic [TID_W-1:0]   cond_tid,
    input  logic               snoop_valid,
    input  logic [ADDR_W-1:0]  snoop_addr,
    input  logic [BE_W-1:0]    snoop_be,
    output logic               sc_ok,
    output logic               store_en,
    output logic [ADDR_W-1:0]  store_addr
);
    import llsc_pkg::*;

    typedef struct packed {
        resv_kind_e          kind;
        logic [ADDR_W-1:0]   addr;
        logic [TID_W-1:0]    owner;
    } resv_t;

    localparam resv_t RESV_EMPTY = '{kind: RK_NONE, addr: '0, owner: '0};

    resv_t resv_d;
    resv_t resv_q;
    logic  grant;
    logic  kill;

    llsc_cond_match #(.ADDR_W(ADDR_W), .TID_W(TID_W)) u_match (
        .kind_q     (resv_q.kind),
        .addr_q     (resv_q.addr),
        .owner_q    (resv_q.owner),
        .cond_valid (cond_valid),
        .cond_dword (cond_dword),
        .cond_addr  (cond_addr),
        .cond_tid   (cond_tid),
        .grant      (grant)
    );

    llsc_snoop_hit #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_snoop (
        .kind_q      (resv_q.kind),
        .addr_q      (resv_q.addr),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .snoop_be    (snoop_be),
        .kill        (kill)
    );

    llsc_store_align #(.ADDR_W(ADDR_W)) u_align (
        .grant      (grant),
        .dword      (cond_dword),
        .addr       (cond_addr),
        .store_addr (store_addr)
    );

    // Next reservation: a new link wins, then the grant's clear, then a snoop kill.
    always_comb begin
        resv_d = resv_q;
        if (link_valid) begin
            resv_d.kind  = kind_of(link_dword);
            resv_d.addr  = link_addr;
            resv_d.owner = link_tid;
        end else if (grant || kill) begin
            resv_d = RESV_EMPTY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_q <= RESV_EMPTY;
        end else begin
            resv_q <= resv_d;
        end
    end

    assign sc_ok    = grant;
    assign store_en = grant;

endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk #(
    parameter int ADDR_W = 64,
    parameter int TID_W  = 8,
    parameter int BE_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               link_valid,
    input logic               link_dword,
    input logic [ADDR_W-1:0]  link_addr,
    input logic [TID_W-1:0]   link_tid,
    input logic               cond_valid,
    input logic               cond_dword,
    input logic [ADDR_W-1:0]  cond_addr,
    input logic [TID_W-1:0]   cond_tid,
    input logic               snoop_valid,
    input logic [ADDR_W-1:0]  snoop_addr,
    input logic [BE_W-1:0]    snoop_be,
    input logic               sc_ok,
    input logic               store_en,
    input logic [ADDR_W-1:0]  store_addr,
    input logic [1:0]         kind_q,
    input logic [ADDR_W-1:0]  addr_q,
    input logic [TID_W-1:0]   owner_q
);
    localparam logic [ADDR_W-1:0] BLK = ~(ADDR_W'(BE_W) - ADDR_W'(1));

    p_store_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        store_en |-> cond_valid);

    p_width_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |-> (kind_q == (cond_dword ? 2'd2 : 2'd1)));

    p_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |-> (cond_tid == owner_q));

    p_exact_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |-> (cond_addr == addr_q));

    p_link_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |=> (kind_q == ($past(link_dword) ? 2'd2 : 2'd1))
                       && (owner_q == $past(link_tid)) && (addr_q == $past(link_addr)));

    p_snoop_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && (snoop_be != '0) && !link_valid && ((snoop_addr & BLK) == (addr_q & BLK)))
        |=> (kind_q == 2'd0));

    p_consume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_ok && !link_valid) |=> (kind_q == 2'd0) && (owner_q == '0) && (addr_q == '0));

    p_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
        store_en |-> ((store_addr & (cond_dword ? ADDR_W'(7) : ADDR_W'(3))) == '0));

endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(
    .ADDR_W(ADDR_W), .TID_W(TID_W), .BE_W(BE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .link_valid(link_valid), .link_dword(link_dword), .link_addr(link_addr), .link_tid(link_tid),
    .cond_valid(cond_valid), .cond_dword(cond_dword), .cond_addr(cond_addr), .cond_tid(cond_tid),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_be(snoop_be),
    .sc_ok(sc_ok), .store_en(store_en), .store_addr(store_addr),
    .kind_q(resv_q.kind), .addr_q(resv_q.addr), .owner_q(resv_q.owner)
);

// File: tb/llsc_resv_monitor_test.sv
`timescale 1ns/1ps
module llsc_resv_monitor_test;
    localparam int ADDR_W = 64;
    localparam int TID_W  = 8;
    localparam int BE_W   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_valid = 0, link_dword = 0, cond_valid = 0, cond_dword = 0, snoop_valid = 0;
    logic [ADDR_W-1:0] link_addr = '0, cond_addr = '0, snoop_addr = '0;
    logic [TID_W-1:0]  link_tid = '0, cond_tid = '0;
    logic [BE_W-1:0]   snoop_be = '0;
    logic sc_ok, store_en;
    logic [ADDR_W-1:0] store_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Behavioural reference state
    int                m_kind = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic [TID_W-1:0]  m_tid  = '0;

    always #5 clk = ~clk;

    llsc_resv_monitor #(.ADDR_W(ADDR_W), .TID_W(TID_W), .BE_W(BE_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .link_valid(link_valid), .link_dword(link_dword), .link_addr(link_addr), .link_tid(link_tid),
        .cond_valid(cond_valid), .cond_dword(cond_dword), .cond_addr(cond_addr), .cond_tid(cond_tid),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_be(snoop_be),
        .sc_ok(sc_ok), .store_en(store_en), .store_addr(store_addr)
    );

    task automatic step(input string req,
                        input logic lv, input logic ld, input logic [63:0] la, input logic [7:0] lt,
                        input logic cv, input logic cd, input logic [63:0] ca, input logic [7:0] ct,
                        input logic sv, input logic [63:0] sa, input logic [7:0] sbe);
        logic exp_ok;
        logic [63:0] exp_addr;
        @(negedge clk);
        link_valid = lv; link_dword = ld; link_addr = la; link_tid = lt;
        cond_valid = cv; cond_dword = cd; cond_addr = ca; cond_tid = ct;
        snoop_valid = sv; snoop_addr = sa; snoop_be = sbe;
        #1;
        exp_ok = cv && (m_kind == (cd ? 2 : 1)) && (ct == m_tid) && (ca == m_addr);
        exp_addr = exp_ok ? (cd ? (ca & ~64'd7) : (ca & ~64'd3)) : 64'd0;
        n_cmp++;
        if (sc_ok !== exp_ok || store_en !== exp_ok || store_addr !== exp_addr) begin
            n_bad++;
            $display("FAIL %s: ok=%0b en=%0b addr=%h expected ok=%0b en=%0b addr=%h",
                     req, sc_ok, store_en, store_addr, exp_ok, exp_ok, exp_addr);
        end
        if (lv) begin
            m_kind = ld ? 2 : 1; m_addr = la; m_tid = lt;
        end else if (exp_ok || (sv && sbe != 0 && m_kind != 0 && (sa[63:3] == m_addr[63:3]))) begin
            m_kind = 0; m_addr = '0; m_tid = '0;
        end
    endtask

    task automatic ll(input string req, input logic d, input logic [63:0] a, input logic [7:0] t);
        step(req, 1, d, a, t, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic sc(input string req, input logic d, input logic [63:0] a, input logic [7:0] t);
        step(req, 0, 0, 0, 0, 1, d, a, t, 0, 0, 0);
    endtask

    task automatic snoop(input string req, input logic [63:0] a, input logic [7:0] be);
        step(req, 0, 0, 0, 0, 0, 0, 0, 0, 1, a, be);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing reserved after reset
        sc("R1", 0, 64'h100, 8'd1);
        sc("R1", 1, 64'h0, 8'd0);
        // R2, R11, R9
        ll("R2", 0, 64'h1006, 8'd1);
        sc("R2", 0, 64'h1006, 8'd1);
        sc("R9", 0, 64'h1006, 8'd1);
        // R3, R11
        ll("R3", 1, 64'h200D, 8'd2);
        sc("R3", 1, 64'h200D, 8'd2);
        // R4 both directions, R10 reservation survives a failure
        ll("R4", 1, 64'h3000, 8'd3);
        sc("R4", 0, 64'h3000, 8'd3);
        sc("R10", 1, 64'h3000, 8'd3);
        ll("R4", 0, 64'h3010, 8'd3);
        sc("R4", 1, 64'h3010, 8'd3);
        sc("R10", 0, 64'h3010, 8'd3);
        // R5
        ll("R5", 0, 64'h4000, 8'd4);
        sc("R5", 0, 64'h4000, 8'd5);
        sc("R5", 0, 64'h4000, 8'd4);
        // R6
        ll("R6", 0, 64'h5004, 8'd1);
        sc("R6", 0, 64'h5000, 8'd1);
        sc("R6", 0, 64'h5005, 8'd1);
        sc("R6", 0, 64'h5004, 8'd1);
        // R7
        ll("R7", 0, 64'h6000, 8'd1);
        ll("R7", 1, 64'h7000, 8'd2);
        sc("R7", 0, 64'h6000, 8'd1);
        sc("R7", 1, 64'h7000, 8'd2);
        // R8
        ll("R8", 0, 64'h8004, 8'd1);
        snoop("R8", 64'h8008, 8'hFF);
        snoop("R8", 64'h8000, 8'h00);
        snoop("R8", 64'h7FF8, 8'hFF);
        sc("R8", 0, 64'h8004, 8'd1);
        ll("R8", 1, 64'h8004, 8'd1);
        snoop("R8", 64'h8007, 8'h80);
        sc("R8", 1, 64'h8004, 8'd1);
        // R12: collisions in one cycle
        step("R12", 1, 0, 64'h9000, 8'd1, 1, 0, 64'h9000, 8'd1, 0, 0, 0);
        sc("R12", 0, 64'h9000, 8'd1);
        ll("R12", 0, 64'hA000, 8'd2);
        step("R12", 1, 1, 64'hB000, 8'd3, 1, 0, 64'hA000, 8'd2, 1, 64'hB000, 8'hFF);
        sc("R12", 1, 64'hB000, 8'd3);
        ll("R12", 0, 64'hC000, 8'd1);
        step("R12", 0, 0, 0, 0, 1, 0, 64'hC000, 8'd1, 1, 64'hC000, 8'hFF);
        // Mixed traffic over a small address and thread pool
        for (int i = 0; i < 400; i++) begin
            step("R12",
                 ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                 64'h100 + 64'($urandom_range(0, 20)), 8'($urandom_range(0, 2)),
                 ($urandom_range(0, 1) == 0), 1'($urandom_range(0, 1)),
                 64'h100 + 64'($urandom_range(0, 20)), 8'($urandom_range(0, 2)),
                 ($urandom_range(0, 4) == 0), 64'h100 + 64'($urandom_range(0, 24)),
                 8'($urandom_range(0, 3)));
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule